// File: doc/BRIEF.md
# Quadratic-Rotation Block Decryption Core

This block turns one 128-bit ciphertext block back into plaintext for a 20-round cipher whose rounds use data-dependent rotations driven by the quadratic function x·(2x+1). The block is held as four 32-bit words named A, B, C and D. Decryption has three phases. In the first, two output whitening keys are subtracted. The rounds then run from the last one down to the first, one round per clock. In the last phase, the two input whitening keys are subtracted.

Each reverse round works in four steps. It first rotates the four words back by one position. It then recomputes the two rotation amounts from the shifted B and D words. Next it subtracts the round's two keys from A and C, and rotates each result right. Finally it XORs in the opposite rotation amount.

Round keys come from outside, through a fetch port. The core drives a key-pair index. Storage outside the core returns the even and odd key words of that pair in the same cycle, with no register in between. Blocks enter through a valid/ready handshake. Results leave as a one-cycle strobe, and the core does not accept back-pressure on its output. The caller must keep the key storage stable while a block is in flight.

Top module: `qrd_decrypt`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, out_block is zero and key_pair is 21.
- R2: A block is taken on a rising edge where in_valid and in_ready are both 1. From the next cycle until the result strobe, in_ready is 0. Any in_valid or in_block driven while in_ready is 0 has no effect on the result.
- R3: out_valid is 1 for exactly one cycle. It follows the 21st rising edge after the accepting edge, so 22 edges are counted including the accepting one. in_ready is 1 in that same cycle, so a new block can be taken at the next edge.
- R4: key_pair selects the key words. key_even must carry S[2·key_pair] and key_odd must carry S[2·key_pair+1], both sampled in the cycle they are addressed. While idle, key_pair is 21. In the cycle after acceptance it is 20. It then steps down by one each cycle and reaches 0 in the cycle before the strobe.
- R5: Word packing in in_block and out_block is as follows: A is bits 31:0, B is bits 63:32, C is bits 95:64 and D is bits 127:96. Each word holds four little-endian bytes of the block.
- R6: On acceptance, the core computes C − S[43] and A − S[42], both modulo 2^32.
- R7: Round i runs for i = 20 down to 1. It first sets (A,B,C,D) to the old (D,A,B,C). It then forms u = (D·(2D+1)) rotated left by 5 and t = (B·(2B+1)) rotated left by 5. Finally it sets C = ((C − S[2i+1]) rotated right by t[4:0]) XOR u, and A = ((A − S[2i]) rotated right by u[4:0]) XOR t.
- R8: The result is formed by subtracting S[0] from B and S[1] from D.
- R9: With an all-zero 16-byte key, the ciphertext 8fc3a53656b1f778c129df4e9848a41e (as bytes, packed per R5) decrypts to an all-zero block.
- R10: For any key expanded by the cipher's key schedule and any plaintext P, feeding the encryption of P yields P.
- R11: out_block holds its last result in every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Ciphertext block offered |
| in_ready | output | 1 | Core idle and able to take a block |
| in_block | input | 128 | Ciphertext block, packed per R5 |
| out_valid | output | 1 | One-cycle strobe: out_block carries a new plaintext |
| out_block | output | 128 | Plaintext block, packed per R5 |
| key_pair | output | 5 | Index of the key pair being fetched |
| key_even | input | 32 | Key word S[2·key_pair] |
| key_odd | input | 32 | Key word S[2·key_pair+1] |

## Verification
The cipher has strong diffusion, so a single wrong bit in any of the four state words shows up in the result. The same is true of a wrong key index, a wrong rotation direction or a wrong word order: each turns the whole 128-bit plaintext into unrelated data, which the round-trip comparison catches at the very next strobe. Faults in control do not need a full decryption to appear. A counter that is off by one moves the strobe away from the 22nd edge, and a key index that is off by one changes the key_pair sequence within a cycle or two of acceptance. Both are checked directly at the ports.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  localparam int WORD_W = 32;
  localparam int LG_W   = $clog2(WORD_W);
  localparam int BLK_W  = 4 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LG_W-1:0]   amt_t;

  // d occupies the top word, a the bottom word
  typedef struct packed {
    word_t d;
    word_t c;
    word_t b;
    word_t a;
  } quad_t;

  // x*(2x+1) modulo 2^WORD_W, then the fixed left rotation by LG_W
  function automatic word_t quad_mix(word_t x);
    word_t p;
    p = x * {x[WORD_W-2:0], 1'b1};
    return {p[WORD_W-LG_W-1:0], p[WORD_W-1:WORD_W-LG_W]};
  endfunction

  function automatic word_t rot_right(word_t x, amt_t s);
    return (x >> s) | (x << (WORD_W - int'(s)));
  endfunction
endpackage

// File: rtl/qrd_round.sv
module qrd_round
  import qrd_pkg::*;
(
  input  quad_t st_i,
  input  word_t k_even,
  input  word_t k_odd,
  output quad_t st_o
);
  quad_t m;
  word_t t_amt;
  word_t u_amt;

  always_comb begin
    // undo the register shift: new (A,B,C,D) = old (D,A,B,C)
    m.a = st_i.d;
    m.b = st_i.a;
    m.c = st_i.b;
    m.d = st_i.c;
    u_amt = quad_mix(m.d);
    t_amt = quad_mix(m.b);
    st_o.a = rot_right(m.a - k_even, u_amt[LG_W-1:0]) ^ t_amt;
    st_o.b = m.b;
    st_o.c = rot_right(m.c - k_odd, t_amt[LG_W-1:0]) ^ u_amt;
    st_o.d = m.d;
  end
endmodule

// File: rtl/qrd_whiten.sv
module qrd_whiten
  import qrd_pkg::*;
#(
  parameter bit FINAL = 1'b0
) (
  input  quad_t st_i,
  input  word_t k_even,
  input  word_t k_odd,
  output quad_t st_o
);
  generate
    if (FINAL) begin : g_final
      assign st_o.a = st_i.a;
      assign st_o.b = st_i.b - k_even;
      assign st_o.c = st_i.c;
      assign st_o.d = st_i.d - k_odd;
    end else begin : g_first
      assign st_o.a = st_i.a - k_even;
      assign st_o.b = st_i.b;
      assign st_o.c = st_i.c - k_odd;
      assign st_o.d = st_i.d;
    end
  endgenerate
endmodule

// File: rtl/qrd_seq.sv
module qrd_seq #(
  parameter int ROUNDS = 20,
  parameter int PAIR_W = $clog2(ROUNDS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              accept,
  output logic              step_round,
  output logic              step_final,
  output logic [PAIR_W-1:0] key_pair,
  output logic              out_valid
);
  localparam logic [PAIR_W-1:0] IDLE_PAIR  = PAIR_W'(ROUNDS + 1);
  localparam logic [PAIR_W-1:0] FIRST_PAIR = PAIR_W'(ROUNDS);

  logic              busy;
  logic [PAIR_W-1:0] rnd;

  assign in_ready   = !busy;
  assign accept     = in_valid && !busy;
  assign step_round = busy && (rnd != '0);
  assign step_final = busy && (rnd == '0);
  assign key_pair   = busy ? rnd : IDLE_PAIR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rnd       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= step_final;
      if (accept) begin
        busy <= 1'b1;
        rnd  <= FIRST_PAIR;
      end else if (step_round) begin
        rnd <= rnd - 1'b1;
      end else if (step_final) begin
        busy <= 1'b0;
      end
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready); // R2
  AST_START_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (key_pair == FIRST_PAIR)); // R4
  AST_PAIR_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && key_pair != '0) |=> (key_pair == $past(key_pair) - 1'b1)); // R4
  AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(key_pair) == '0 && $past(!in_ready))); // R3
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R3
  AST_READY_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready); // R3
endmodule

// File: rtl/qrd_decrypt.sv
module qrd_decrypt
  import qrd_pkg::*;
#(
  parameter int ROUNDS = 20,
  localparam int PAIR_W = $clog2(ROUNDS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_block,
  output logic              out_valid,
  output logic [BLK_W-1:0]  out_block,
  output logic [PAIR_W-1:0] key_pair,
  input  logic [WORD_W-1:0] key_even,
  input  logic [WORD_W-1:0] key_odd
);
  logic  accept;
  logic  step_round;
  logic  step_final;
  quad_t st;
  quad_t first_w;
  quad_t round_w;
  quad_t final_w;

  qrd_seq #(.ROUNDS(ROUNDS), .PAIR_W(PAIR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .accept     (accept),
    .step_round (step_round),
    .step_final (step_final),
    .key_pair   (key_pair),
    .out_valid  (out_valid)
  );

  qrd_whiten #(.FINAL(1'b0)) u_first (
    .st_i   (quad_t'(in_block)),
    .k_even (key_even),
    .k_odd  (key_odd),
    .st_o   (first_w)
  );

  qrd_round u_round (
    .st_i   (st),
    .k_even (key_even),
    .k_odd  (key_odd),
    .st_o   (round_w)
  );

  qrd_whiten #(.FINAL(1'b1)) u_final (
    .st_i   (st),
    .k_even (key_even),
    .k_odd  (key_odd),
    .st_o   (final_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= '0;
      out_block <= '0;
    end else begin
      if (accept) begin
        st <= first_w;
      end else if (step_round) begin
        st <= round_w;
      end
      if (step_final) begin
        out_block <= final_w;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_block)); // R11
  AST_STATE_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ready) && !$past(in_valid)) |-> $stable(st)); // R2
endmodule

// File: tb/tb_qrd_decrypt.sv
`timescale 1ns/1ps
module tb_qrd_decrypt;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_block = '0;
  logic         out_valid;
  logic [127:0] out_block;
  logic [4:0]   key_pair;
  logic [31:0]  key_even;
  logic [31:0]  key_odd;

  logic [31:0]  S_tb [44];
  logic [127:0] exp_q [$];
  int           stamp_q [$];
  int           cyc = 0;
  int           checks = 0;
  int           errors = 0;
  logic [127:0] last_pt = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign key_even = S_tb[2 * int'(key_pair)];
  assign key_odd  = S_tb[2 * int'(key_pair) + 1];

  qrd_decrypt dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .out_valid(out_valid), .out_block(out_block),
    .key_pair(key_pair), .key_even(key_even), .key_odd(key_odd)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    int k;
    k = s & 31;
    return (k == 0) ? x : ((x << k) | (x >> (32 - k)));
  endfunction

  function automatic logic [31:0] qf(input logic [31:0] x);
    logic [31:0] p;
    p = x * (2 * x + 32'd1);
    return rl(p, 5);
  endfunction

  task automatic expand(input logic [31:0] k0, k1, k2, k3);
    logic [31:0] L [4];
    logic [31:0] a, b;
    int i, j;
    L[0] = k0; L[1] = k1; L[2] = k2; L[3] = k3;
    S_tb[0] = 32'hB7E15163;
    for (int n = 1; n < 44; n++) S_tb[n] = S_tb[n-1] + 32'h9E3779B9;
    a = '0; b = '0; i = 0; j = 0;
    for (int s = 0; s < 132; s++) begin
      a = rl(S_tb[i] + a + b, 3);
      S_tb[i] = a;
      b = rl(L[j] + a + b, int'((a + b) & 32'd31));
      L[j] = b;
      i = (i + 1) % 44;
      j = (j + 1) % 4;
    end
  endtask

  function automatic logic [127:0] enc(input logic [127:0] p);
    logic [31:0] a, b, c, d, t, u, x;
    a = p[31:0]; b = p[63:32]; c = p[95:64]; d = p[127:96];
    b = b + S_tb[0];
    d = d + S_tb[1];
    for (int i = 1; i <= 20; i++) begin
      t = qf(b);
      u = qf(d);
      a = rl(a ^ t, int'(u[4:0])) + S_tb[2*i];
      c = rl(c ^ u, int'(t[4:0])) + S_tb[2*i+1];
      x = a; a = b; b = c; c = d; d = x;
    end
    a = a + S_tb[42];
    c = c + S_tb[43];
    return {d, c, b, a};
  endfunction

  // driver: offers a block, records the expected plaintext and accepting edge
  task automatic send(input logic [127:0] ct, input logic [127:0] pt);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_block = ct;
    exp_q.push_back(pt);
    stamp_q.push_back(cyc + 1);
    last_pt = pt;
    @(negedge clk);
    chk(!in_ready, "R2 ready low after accept", {127'd0, in_ready}, 128'd0);
    chk(key_pair == 5'd20, "R4 first round pair", {123'd0, key_pair}, 128'd20);
    in_block = ~ct;  // offered while busy: must be ignored (R2)
    @(negedge clk);
    chk(key_pair == 5'd19, "R4 descending pair", {123'd0, key_pair}, 128'd19);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares each strobe with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected strobe", out_block, '0);
      end else begin
        logic [127:0] e;
        int st;
        e = exp_q.pop_front();
        st = stamp_q.pop_front();
        chk(out_block == e, "R5 R6 R7 R8 R10 plaintext", out_block, e);
        chk(cyc == st + 21, "R3 latency", 128'(cyc - st), 128'd21);
        chk(in_ready, "R3 ready at strobe", {127'd0, in_ready}, 128'd1);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] p;
    expand('0, '0, '0, '0);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", {127'd0, in_ready}, 128'd1);
    chk(out_valid == 1'b0, "R1 out_valid", {127'd0, out_valid}, 128'd0);
    chk(out_block == '0, "R1 out_block", out_block, '0);
    chk(key_pair == 5'd21, "R1 R4 idle pair", {123'd0, key_pair}, 128'd21);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // known answer, zero key
    chk(enc('0) == 128'h1ea44898_4edf29c1_78f7b156_36a5c38f, "R9 bench model",
        enc('0), 128'h1ea44898_4edf29c1_78f7b156_36a5c38f);
    send(128'h1ea44898_4edf29c1_78f7b156_36a5c38f, '0);  // R9
    drain();

    // fixed patterns under zero key
    send(enc({128{1'b1}}), {128{1'b1}});
    send(enc({64{2'b10}}), {64{2'b10}});
    send(enc(128'h00000001_00000000_00000000_00000000), 128'h00000001_00000000_00000000_00000000);
    drain();
    repeat (5) @(negedge clk);
    chk(out_block == last_pt, "R11 hold while idle", out_block, last_pt);
    chk(key_pair == 5'd21, "R4 idle pair again", {123'd0, key_pair}, 128'd21);

    // random keys, back-to-back blocks
    for (int k = 0; k < 6; k++) begin
      expand($urandom, $urandom, $urandom, $urandom);
      for (int j = 0; j < 4; j++) begin
        p = {$urandom, $urandom, $urandom, $urandom};
        send(enc(p), p);  // R10
      end
      drain();
    end
    repeat (4) @(negedge clk);
    chk(out_block == last_pt, "R11 final hold", out_block, last_pt);
    chk(out_valid == 1'b0, "R3 no extra strobe", {127'd0, out_valid}, 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule